// File: doc/BRIEF.md
# Card Command Sequencer with Response Capture

This block runs one card command at a time for a memory-card host. Software loads a 6-bit command index and a 32-bit argument (the argument arrives as two independent 16-bit halves), then writes a configuration word. The configuration word selects the expected response type, whether a data phase follows, and whether the command is held back. The command goes out either at once, when the card clock is already running, or on the next clock-start request while it is still pending. The index and argument are latched at issue and presented to the card side on a valid/ready request.

The card side answers with a stream of response bytes and a completion strobe that carries the byte count. The bytes are packed two to a 16-bit slot in a nine-slot response buffer, which is cleared at every issue. Software drains the buffer through a single read port. The byte count is checked against the minimum length of the selected response type. A short answer sets a timeout flag. A long enough answer sets a response-done flag and, if a data phase was requested, emits a start pulse with the total byte count (block count times block length) for the data engine.

Top module: `sdc_cmd_ctrl`

Register word addresses: 0 clock control (bit 1 start, bit 0 stop), 1 configuration, 2 command index, 3 argument high half, 4 argument low half, 5 block length, 6 block count, 7 response port, 8 status, 9 end-of-command flag (bit 0; writing 1 clears it).

## Requirements
- R1: The command index holds 6 bits; a read of address 2 returns the index with bit 6 set to 1.
- R2: A write to address 3 replaces only argument bits 31:16, and a write to address 4 replaces only bits 15:0; each reads back on its own address.
- R3: A configuration write stores the written value ANDed with 0x3dff, abandons any command in progress and marks a command pending. Configuration bits 1:0 hold the response type, bit 2 enables the data phase, and bit 10 holds the command back.
- R4: A configuration write with bit 10 clear issues the command in the next cycle when the clock is enabled. The request then stays valid, with a stable index and argument, until it is accepted.
- R5: With the clock stopped, a configuration write does not issue. A later clock start (address 0 bit 1) issues if a command is pending and configuration bit 10 is clear.
- R6: Issue clears the pending mark, so a repeated clock start does not issue the same command again.
- R7: Response type 0 needs no bytes, types 1 and 3 need at least 4 bytes, and type 2 needs at least 16 bytes. A shorter count sets status bit 1 and clears status bit 13.
- R8: A long enough count sets status bit 13. Every completion sets the end-of-command flag (address 9 bit 0 and output `endcmd_irq`), and writing 1 to bit 0 of address 9 clears the flag.
- R9: Response byte 2k goes to bits 7:0 of slot k and byte 2k+1 to bits 15:8. Every slot is zero after issue, until bytes are written into it.
- R10: After a successful completion, successive reads of address 7 return slots 0 to 8 in order. All later reads return 0.
- R11: On success with configuration bit 2 set, `xfer_start` pulses for one cycle with `xfer_bytes` equal to block count (16 bits) times block length (12 bits). It does not pulse on a timeout or when bit 2 is clear.
- R12: A clock stop (address 0 bit 0) clears status bit 8 and drops any outstanding request. Status bit 8 reads 1 while the clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| card_req_valid | output | 1 | Command request to the card side |
| card_req_ready | input | 1 | Card side accepts the request |
| card_req_index | output | 6 | Latched command index |
| card_req_arg | output | 32 | Latched command argument |
| card_byte_valid | input | 1 | Response byte strobe |
| card_byte | input | 8 | Response byte |
| card_done | input | 1 | Response finished |
| card_len | input | 5 | Number of response bytes returned |
| xfer_start | output | 1 | Data phase start pulse |
| xfer_bytes | output | 28 | Total data phase byte count |
| endcmd_irq | output | 1 | End-of-command flag |

## Verification
Each register read returns its data in `bus_rdata` one cycle after the read strobe. An issue triggered by a write shows on `card_req_valid` one cycle after the write. Status, the end-of-command flag and `xfer_start` change in the cycle after `card_done` is sampled. The bench drives every input on the falling edge and samples on the next falling edge after the capturing rising edge. Read results go through a queue of expected values that a falling-edge monitor pops. Handshake, pulse and flag outputs are compared directly at those falling edges.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RA_CLKCTL = 4'd0;
  localparam logic [REG_AW-1:0] RA_CFG    = 4'd1;
  localparam logic [REG_AW-1:0] RA_CMD    = 4'd2;
  localparam logic [REG_AW-1:0] RA_ARGH   = 4'd3;
  localparam logic [REG_AW-1:0] RA_ARGL   = 4'd4;
  localparam logic [REG_AW-1:0] RA_BLKLEN = 4'd5;
  localparam logic [REG_AW-1:0] RA_BLKCNT = 4'd6;
  localparam logic [REG_AW-1:0] RA_RESP   = 4'd7;
  localparam logic [REG_AW-1:0] RA_STATUS = 4'd8;
  localparam logic [REG_AW-1:0] RA_IRQ    = 4'd9;

  localparam int CFG_W = 14;
  localparam logic [CFG_W-1:0] CFG_KEEP = 14'h3dff;
  localparam int CFG_DEN  = 2;
  localparam int CFG_STOP = 10;

  localparam int STAT_W    = 16;
  localparam int SB_TOUT   = 1;
  localparam int SB_CLKON  = 8;
  localparam int SB_RESPOK = 13;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RESP} sq_state_t;
endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  parameter int ENT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [STAT_W-1:0]   status_word,
  input  logic                irq_flag,
  input  logic [ENT_W-1:0]    resp_head,
  output logic [CFG_W-1:0]    cfg,
  output logic [IDX_W-1:0]    cmd_idx,
  output logic [ARG_W-1:0]    arg,
  output logic [BLKLEN_W-1:0] blklen,
  output logic [BLKCNT_W-1:0] blkcnt,
  output logic                ev_cfg_wr,
  output logic                ev_cfg_stop,
  output logic                ev_clk_start,
  output logic                ev_clk_stop,
  output logic                ev_irq_clr,
  output logic                resp_pop
);
  localparam int HALF = ARG_W / 2;

  always_comb begin
    ev_cfg_wr    = bus_wr && (bus_addr == RA_CFG);
    ev_cfg_stop  = bus_wdata[CFG_STOP];
    ev_clk_start = bus_wr && (bus_addr == RA_CLKCTL) && bus_wdata[1];
    ev_clk_stop  = bus_wr && (bus_addr == RA_CLKCTL) && bus_wdata[0];
    ev_irq_clr   = bus_wr && (bus_addr == RA_IRQ) && bus_wdata[0];
    resp_pop     = bus_rd && (bus_addr == RA_RESP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      cmd_idx <= '0;
      arg     <= '0;
      blklen  <= '0;
      blkcnt  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        RA_CFG:    cfg             <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
        RA_CMD:    cmd_idx         <= bus_wdata[IDX_W-1:0];
        RA_ARGH:   arg[ARG_W-1:HALF] <= bus_wdata[HALF-1:0];
        RA_ARGL:   arg[HALF-1:0]   <= bus_wdata[HALF-1:0];
        RA_BLKLEN: blklen          <= bus_wdata[BLKLEN_W-1:0];
        RA_BLKCNT: blkcnt          <= bus_wdata[BLKCNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_CFG:    bus_rdata <= DATA_W'(cfg);
        RA_CMD:    bus_rdata <= DATA_W'({1'b1, cmd_idx});
        RA_ARGH:   bus_rdata <= DATA_W'(arg[ARG_W-1:HALF]);
        RA_ARGL:   bus_rdata <= DATA_W'(arg[HALF-1:0]);
        RA_BLKLEN: bus_rdata <= DATA_W'(blklen);
        RA_BLKCNT: bus_rdata <= DATA_W'(blkcnt);
        RA_RESP:   bus_rdata <= DATA_W'(resp_head);
        RA_STATUS: bus_rdata <= DATA_W'(status_word);
        RA_IRQ:    bus_rdata <= DATA_W'(irq_flag);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_CMD_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == RA_CMD) |=> bus_rdata[IDX_W]); // R1
endmodule

// File: rtl/sdc_resp_fifo.sv
module sdc_resp_fifo #(
  parameter int ENTRIES = 9,
  parameter int ENT_W   = 16,
  parameter int BYTES   = 2 * ENTRIES,
  parameter int BIDX_W  = $clog2(BYTES),
  parameter int PTR_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              pop,
  input  logic              rewind,
  output logic [ENT_W-1:0]  head
);
  logic [ENT_W-1:0] slot [ENTRIES];
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < ENTRIES; i++) slot[i] <= '0;
    end else if (wr_en && (wr_idx < BIDX_W'(BYTES))) begin
      if (wr_idx[0]) slot[wr_idx[BIDX_W-1:1]][15:8] <= wr_byte;
      else           slot[wr_idx[BIDX_W-1:1]][7:0]  <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rewind) rd_ptr <= '0;
    else if (pop && (rd_ptr < PTR_W'(ENTRIES))) rd_ptr <= rd_ptr + 1'b1;
  end

  assign head = (rd_ptr < PTR_W'(ENTRIES)) ? slot[rd_ptr] : '0;

  AST_RPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_ptr <= PTR_W'(ENTRIES)); // R10
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (pop && !rewind && rd_ptr < PTR_W'(ENTRIES)) |=> rd_ptr == $past(rd_ptr) + 1'b1); // R10
endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
  import sdc_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int LEN_W    = 5,
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  parameter int BYTES    = 18,
  parameter int BIDX_W   = $clog2(BYTES),
  parameter int XB_W     = BLKLEN_W + BLKCNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_cfg_wr,
  input  logic                ev_cfg_stop,
  input  logic                ev_clk_start,
  input  logic                ev_clk_stop,
  input  logic                ev_irq_clr,
  input  logic [1:0]          resp_type,
  input  logic                data_en,
  input  logic                cfg_stop,
  input  logic [IDX_W-1:0]    cmd_idx,
  input  logic [ARG_W-1:0]    arg,
  input  logic [BLKLEN_W-1:0] blklen,
  input  logic [BLKCNT_W-1:0] blkcnt,
  output logic                card_req_valid,
  input  logic                card_req_ready,
  output logic [IDX_W-1:0]    card_req_index,
  output logic [ARG_W-1:0]    card_req_arg,
  input  logic                card_byte_valid,
  input  logic                card_done,
  input  logic [LEN_W-1:0]    card_len,
  output logic                fifo_clear,
  output logic                fifo_wr,
  output logic [BIDX_W-1:0]   fifo_wr_idx,
  output logic                fifo_rewind,
  output logic                xfer_start,
  output logic [XB_W-1:0]     xfer_bytes,
  output logic [STAT_W-1:0]   status_word,
  output logic                irq_flag
);
  sq_state_t         state;
  logic              pending, clk_en, st_tout, st_respok;
  logic [BIDX_W-1:0] byte_ptr;
  logic              issue, abort, finish, short_rsp;
  logic [LEN_W-1:0]  need;

  always_comb begin
    issue = (ev_cfg_wr && !ev_cfg_stop && clk_en)
         || (ev_clk_start && !ev_clk_stop && pending && !cfg_stop);
    abort = ev_cfg_wr || ev_clk_stop;
    case (resp_type)
      2'd0:    need = '0;
      2'd2:    need = LEN_W'(16);
      default: need = LEN_W'(4);
    endcase
    short_rsp   = card_len < need;
    finish      = (state == SQ_RESP) && card_done && !abort;
    fifo_clear  = issue;
    fifo_wr     = (state == SQ_RESP) && card_byte_valid && !abort;
    fifo_wr_idx = byte_ptr;
    fifo_rewind = finish && !short_rsp;
    card_req_valid = (state == SQ_REQ);
    status_word = '0;
    status_word[SB_TOUT]   = st_tout;
    status_word[SB_CLKON]  = clk_en;
    status_word[SB_RESPOK] = st_respok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= SQ_IDLE;
      pending        <= 1'b0;
      clk_en         <= 1'b0;
      st_tout        <= 1'b0;
      st_respok      <= 1'b0;
      irq_flag       <= 1'b0;
      byte_ptr       <= '0;
      xfer_start     <= 1'b0;
      xfer_bytes     <= '0;
      card_req_index <= '0;
      card_req_arg   <= '0;
    end else begin
      xfer_start <= 1'b0;
      if (ev_clk_start) clk_en <= 1'b1;
      if (ev_clk_stop)  clk_en <= 1'b0;
      if (ev_irq_clr)   irq_flag <= 1'b0;
      case (state)
        SQ_REQ: if (card_req_ready) state <= SQ_RESP;
        SQ_RESP: begin
          if (card_byte_valid && byte_ptr < BIDX_W'(BYTES)) byte_ptr <= byte_ptr + 1'b1;
          if (finish) begin
            state    <= SQ_IDLE;
            irq_flag <= 1'b1;
            if (short_rsp) st_tout <= 1'b1;
            else begin
              st_respok <= 1'b1;
              if (data_en) begin
                xfer_start <= 1'b1;
                xfer_bytes <= XB_W'(blklen) * XB_W'(blkcnt);
              end
            end
          end
        end
        default: ;
      endcase
      if (ev_cfg_wr)   pending <= 1'b1;
      if (abort)       state   <= SQ_IDLE;
      if (issue) begin
        pending        <= 1'b0;
        state          <= SQ_REQ;
        st_tout        <= 1'b0;
        st_respok      <= 1'b0;
        byte_ptr       <= '0;
        card_req_index <= cmd_idx;
        card_req_arg   <= arg;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (card_req_valid && !card_req_ready && !abort) |=>
      (card_req_valid && $stable(card_req_index) && $stable(card_req_arg))); // R4
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    card_req_valid |-> !pending); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(st_tout && st_respok)); // R7
  AST_XFER_OK: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (st_respok && !st_tout)); // R11
  AST_CLKOFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> !card_req_valid); // R12
endmodule

// File: rtl/sdc_cmd_ctrl.sv
module sdc_cmd_ctrl
  import sdc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int LEN_W    = 5,
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  parameter int ENTRIES  = 9,
  parameter int ENT_W    = 16,
  parameter int XB_W     = BLKLEN_W + BLKCNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              card_req_valid,
  input  logic              card_req_ready,
  output logic [IDX_W-1:0]  card_req_index,
  output logic [ARG_W-1:0]  card_req_arg,
  input  logic              card_byte_valid,
  input  logic [7:0]        card_byte,
  input  logic              card_done,
  input  logic [LEN_W-1:0]  card_len,
  output logic              xfer_start,
  output logic [XB_W-1:0]   xfer_bytes,
  output logic              endcmd_irq
);
  localparam int BYTES  = 2 * ENTRIES;
  localparam int BIDX_W = $clog2(BYTES);

  logic [CFG_W-1:0]    cfg;
  logic [IDX_W-1:0]    cmd_idx;
  logic [ARG_W-1:0]    arg;
  logic [BLKLEN_W-1:0] blklen;
  logic [BLKCNT_W-1:0] blkcnt;
  logic [STAT_W-1:0]   status_word;
  logic [ENT_W-1:0]    resp_head;
  logic                ev_cfg_wr, ev_cfg_stop, ev_clk_start, ev_clk_stop, ev_irq_clr, resp_pop;
  logic                fifo_clear, fifo_wr, fifo_rewind;
  logic [BIDX_W-1:0]   fifo_wr_idx;

  sdc_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .ARG_W(ARG_W),
    .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W), .ENT_W(ENT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
    .irq_flag(endcmd_irq), .resp_head(resp_head), .cfg(cfg), .cmd_idx(cmd_idx),
    .arg(arg), .blklen(blklen), .blkcnt(blkcnt), .ev_cfg_wr(ev_cfg_wr),
    .ev_cfg_stop(ev_cfg_stop), .ev_clk_start(ev_clk_start), .ev_clk_stop(ev_clk_stop),
    .ev_irq_clr(ev_irq_clr), .resp_pop(resp_pop)
  );

  sdc_cmd_fsm #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .LEN_W(LEN_W), .BLKLEN_W(BLKLEN_W),
    .BLKCNT_W(BLKCNT_W), .BYTES(BYTES), .BIDX_W(BIDX_W), .XB_W(XB_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .ev_cfg_wr(ev_cfg_wr), .ev_cfg_stop(ev_cfg_stop),
    .ev_clk_start(ev_clk_start), .ev_clk_stop(ev_clk_stop), .ev_irq_clr(ev_irq_clr),
    .resp_type(cfg[1:0]), .data_en(cfg[CFG_DEN]), .cfg_stop(cfg[CFG_STOP]),
    .cmd_idx(cmd_idx), .arg(arg), .blklen(blklen), .blkcnt(blkcnt),
    .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
    .card_req_index(card_req_index), .card_req_arg(card_req_arg),
    .card_byte_valid(card_byte_valid), .card_done(card_done), .card_len(card_len),
    .fifo_clear(fifo_clear), .fifo_wr(fifo_wr), .fifo_wr_idx(fifo_wr_idx),
    .fifo_rewind(fifo_rewind), .xfer_start(xfer_start), .xfer_bytes(xfer_bytes),
    .status_word(status_word), .irq_flag(endcmd_irq)
  );

  sdc_resp_fifo #(
    .ENTRIES(ENTRIES), .ENT_W(ENT_W), .BYTES(BYTES), .BIDX_W(BIDX_W)
  ) u_fifo (
    .clk(clk), .rst(rst), .clear(fifo_clear), .wr_en(fifo_wr), .wr_idx(fifo_wr_idx),
    .wr_byte(card_byte), .pop(resp_pop), .rewind(fifo_rewind), .head(resp_head)
  );
endmodule

// File: tb/sdc_cmd_ctrl_test.sv
module sdc_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        card_req_valid, card_req_ready = 1'b0;
  logic [5:0]  card_req_index;
  logic [31:0] card_req_arg;
  logic        card_byte_valid = 1'b0;
  logic [7:0]  card_byte = '0;
  logic        card_done = 1'b0;
  logic [4:0]  card_len = '0;
  logic        xfer_start;
  logic [27:0] xfer_bytes;
  logic        endcmd_irq;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit rd_seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdc_cmd_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_req_valid(card_req_valid),
    .card_req_ready(card_req_ready), .card_req_index(card_req_index),
    .card_req_arg(card_req_arg), .card_byte_valid(card_byte_valid), .card_byte(card_byte),
    .card_done(card_done), .card_len(card_len), .xfer_start(xfer_start),
    .xfer_bytes(xfer_bytes), .endcmd_irq(endcmd_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one cycle after the read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R0 unexpected read", bus_rdata, 32'hdead_beef);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic card_reply(input int n, input logic [7:0] base, input logic [5:0] eidx,
                            input logic [31:0] earg, output logic xs, output logic [27:0] xb);
    int w = 0;
    while (!card_req_valid && w < 50) begin @(negedge clk); w++; end
    chk("R4 request seen", {31'b0, card_req_valid}, 32'h1);
    chk("R4 request index", {26'b0, card_req_index}, {26'b0, eidx});
    chk("R4 request argument", card_req_arg, earg);
    card_req_ready = 1'b1;
    @(negedge clk); card_req_ready = 1'b0;
    for (int i = 0; i < n; i++) begin
      card_byte_valid = 1'b1; card_byte = base + 8'(i);
      @(negedge clk);
    end
    card_byte_valid = 1'b0; card_done = 1'b1; card_len = 5'(n);
    @(negedge clk); card_done = 1'b0;
    xs = xfer_start; xb = xfer_bytes;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic xs; logic [27:0] xb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(4'd8, 32'h0, "R12 reset status");
    rd(4'd9, 32'h0, "R8 reset flag");
    rd(4'd2, 32'h40, "R1 reset index readback");
    chk("R4 no request after reset", {31'b0, card_req_valid}, 32'h0);
    // R1
    wr(4'd2, 32'hFF);
    rd(4'd2, 32'h7F, "R1 index masked and bit6");
    // R2
    wr(4'd3, 32'h1234); wr(4'd4, 32'hABCD);
    rd(4'd3, 32'h1234, "R2 high half");
    rd(4'd4, 32'hABCD, "R2 low half");
    wr(4'd3, 32'h5555);
    rd(4'd4, 32'hABCD, "R2 low half kept");
    rd(4'd3, 32'h5555, "R2 high half replaced");
    // R3: stop bit set, no issue
    wr(4'd1, 32'hFFFF);
    rd(4'd1, 32'h3DFF, "R3 config mask");
    chk("R3 held command not issued", {31'b0, card_req_valid}, 32'h0);
    // R5: clock off, then start
    wr(4'd1, 32'h1);
    chk("R5 no issue with clock off", {31'b0, card_req_valid}, 32'h0);
    wr(4'd0, 32'h2);
    card_reply(6, 8'h10, 6'h3F, 32'h5555ABCD, xs, xb);
    chk("R11 no data phase when disabled", {31'b0, xs}, 32'h0);
    rd(4'd8, 32'h2100, "R8 success status");
    rd(4'd9, 32'h1, "R8 flag after completion");
    chk("R8 flag port", {31'b0, endcmd_irq}, 32'h1);
    rd(4'd7, 32'h1110, "R9 slot0 packing");
    rd(4'd7, 32'h1312, "R10 slot1");
    rd(4'd7, 32'h1514, "R10 slot2");
    for (int i = 3; i < 9; i++) rd(4'd7, 32'h0, "R10 unused slot");
    rd(4'd7, 32'h0, "R10 read past end");
    // R6: repeated start does not reissue
    wr(4'd0, 32'h2);
    repeat (3) @(negedge clk);
    chk("R6 no second issue", {31'b0, card_req_valid}, 32'h0);
    // R8 clear
    wr(4'd9, 32'h1);
    rd(4'd9, 32'h0, "R8 flag cleared");
    // R4 immediate issue, R9 zeroing
    wr(4'd1, 32'h1);
    card_reply(4, 8'hA0, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd7, 32'hA1A0, "R9 new slot0");
    rd(4'd7, 32'hA3A2, "R9 new slot1");
    rd(4'd7, 32'h0, "R9 stale slot zeroed");
    // R7 type 2 short
    wr(4'd9, 32'h1);
    wr(4'd1, 32'h2);
    card_reply(8, 8'h30, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd8, 32'h0102, "R7 type2 short timeout");
    rd(4'd9, 32'h1, "R8 flag after timeout");
    wr(4'd1, 32'h2);
    card_reply(16, 8'h40, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd8, 32'h2100, "R7 type2 sixteen bytes ok");
    rd(4'd7, 32'h4140, "R10 rewind after success");
    wr(4'd1, 32'h3);
    card_reply(3, 8'h50, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd8, 32'h0102, "R7 type3 three bytes timeout");
    wr(4'd1, 32'h3);
    card_reply(4, 8'h50, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd8, 32'h2100, "R7 type3 four bytes ok");
    wr(4'd1, 32'h0);
    card_reply(0, 8'h00, 6'h3F, 32'h5555ABCD, xs, xb);
    rd(4'd8, 32'h2100, "R7 type0 no bytes ok");
    // R11 data phase
    wr(4'd5, 32'h200); wr(4'd6, 32'h3);
    wr(4'd1, 32'h5);
    card_reply(4, 8'h60, 6'h3F, 32'h5555ABCD, xs, xb);
    chk("R11 start pulse", {31'b0, xs}, 32'h1);
    chk("R11 byte total", {4'b0, xb}, 32'h600);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'b0, xfer_start}, 32'h0);
    wr(4'd5, 32'hFFFF); wr(4'd6, 32'hFFFF);
    rd(4'd5, 32'hFFF, "R11 block length 12 bits");
    wr(4'd1, 32'h5);
    card_reply(4, 8'h70, 6'h3F, 32'h5555ABCD, xs, xb);
    chk("R11 maximum byte total", {4'b0, xb}, 32'h0FFEF001);
    wr(4'd1, 32'h6);
    card_reply(4, 8'h70, 6'h3F, 32'h5555ABCD, xs, xb);
    chk("R11 no pulse on timeout", {31'b0, xs}, 32'h0);
    // R12 clock stop aborts
    wr(4'd2, 32'h05); wr(4'd1, 32'h1);
    chk("R12 request up before stop", {31'b0, card_req_valid}, 32'h1);
    chk("R4 new index latched", {26'b0, card_req_index}, 32'h5);
    wr(4'd0, 32'h1);
    chk("R12 request dropped", {31'b0, card_req_valid}, 32'h0);
    rd(4'd8, 32'h0, "R12 clock bit cleared");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule